// File: doc/BRIEF.md
# Shift-Register Terminal Count Timer

This block measures a programmed number of enabled clock cycles and raises a single-cycle pulse each time that number has elapsed. It has no adder. A 7-bit register advances through a maximal-length pseudo-random sequence. Its only feedback gate is one two-input XOR. The block compares the register against one precomputed state, which stands for the wanted count. The intermediate register values mean nothing outside the block, and only the pulse leaves it.

The integrator converts the wanted count into a register state offline and passes that state in as the `TERM_STATE` parameter. This is the state the sequence reaches after that many steps from `SEED`. A mode input chooses between two behaviours at the terminal state:

- **Auto-restart:** the register reloads the seed and counting repeats.
- **Halt:** the register holds until software-free logic pulses the reload input.

A parameter adds the all-zero state to the sequence. The period then grows from 2^n-1 to 2^n states, and zero can serve as a terminal state.

Top module: `lfsr_tc_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tcPulse` is low and the register holds `SEED`.
- R2: With `wrapMode`=1 and `enable` held high, `tcPulse` is high in the cycle after every (K+1)-th enabled edge. K is the number of sequence steps from `SEED` to `TERM_STATE`. The pulse repeats with a period of K+1 enabled cycles.
- R3: A clock edge with `enable` low changes nothing: the count resumes where it stopped, and no pulse is produced.
- R4: With `wrapMode`=0, reaching the terminal state gives exactly one pulse. After that no pulse occurs, whatever `enable` does, until `reload` is asserted.
- R5: `reload` returns the register to `SEED` and clears the halted condition. It takes priority over `enable`, and the cycle after it never carries a pulse.
- R6: With `FULL_PERIOD`=1 the sequence also visits the all-zero state. The feedback is inverted whenever the low n-1 bits are all zero, so `TERM_STATE`=0 is reached and counted.
- R7: Every pulse is exactly one cycle wide unless K=0.
- R8: With `FULL_PERIOD`=0 the register never holds all zeros, provided `SEED` is nonzero.
- R9: The next-state logic is a shift with a single XOR of the two tap bits, most significant bit first. The default taps are bits 7 and 6 of a 7-bit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Count this edge |
| reload | input | 1 | Restart the count from the seed |
| wrapMode | input | 1 | 1: restart at terminal count; 0: halt at terminal count |
| tcPulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench runs two instances side by side:

- a plain instance with a short count;
- a full-period instance whose terminal state is all zeros, so a design without working zero insertion never pulses there and every expected pulse is reported missing.

Enable gaps are interleaved with counting. A design that advanced on idle edges would pulse early.

Halt mode runs for several hundred cycles after the first pulse. A design that failed to latch the halt would pulse again one period later.

Reloads are placed mid-count, including one together with enable. A design that let enable win would fire on the old schedule. Pulse timing is compared cycle by cycle, so a pulse that is off by one cycle or wider than one cycle counts as a mismatch.

// File: rtl/lfsr_tc_pkg.sv
package lfsr_tc_pkg;

  // Strobes from control to the datapath register
  typedef struct packed {
    logic load;   // force the register back to the seed
    logic step;   // advance one position in the sequence
  } ctrlStrobes_t;

endpackage

// File: rtl/lfsr_tc_datapath.sv
module lfsr_tc_datapath
  import lfsr_tc_pkg::*;
#(
  parameter int unsigned WIDTH       = 7,
  parameter int unsigned TAP_HI      = 7,
  parameter int unsigned TAP_LO      = 6,
  parameter bit          FULL_PERIOD = 1'b0,
  parameter logic [WIDTH-1:0] SEED       = 7'h01,
  parameter logic [WIDTH-1:0] TERM_STATE = 7'h40
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strb,
  output logic         atTerm
);

  localparam int unsigned HI_IDX = TAP_HI - 1;
  localparam int unsigned LO_IDX = TAP_LO - 1;

  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] nextState;
  logic             tapXor;
  logic             zeroFill;

  assign tapXor = state[HI_IDX] ^ state[LO_IDX];

  generate
    if (FULL_PERIOD) begin : g_full
      // Insert the all-zero state: flip feedback when all but the top bit are clear
      assign zeroFill = ~|state[WIDTH-2:0];
    end else begin : g_plain
      assign zeroFill = 1'b0;

      // R8
      plain_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0)
        else $error("plain sequence entered the all-zero state");
    end
  endgenerate

  assign nextState = {state[WIDTH-2:0], tapXor ^ zeroFill};

  always_ff @(posedge clk) begin
    if (rst || strb.load) begin
      state <= SEED;
    end else if (strb.step) begin
      state <= nextState;
    end
  end

  assign atTerm = (state == TERM_STATE);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.step) |=> $stable(state))
    else $error("register moved without a strobe");

  // R5
  load_seed_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (state == SEED))
    else $error("load did not restore the seed");

endmodule

// File: rtl/lfsr_tc_ctrl.sv
module lfsr_tc_ctrl
  import lfsr_tc_pkg::*;
#(
  parameter bit TERM_IS_SEED = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         reload,
  input  logic         wrapMode,
  input  logic         atTerm,
  output ctrlStrobes_t strb,
  output logic         tcPulse
);

  logic halted;
  logic live;
  logic termEvent;

  assign live      = enable && !reload && !halted;
  assign termEvent = live && atTerm;

  always_comb begin
    strb.load = reload || (termEvent && wrapMode);
    strb.step = live && !atTerm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted  <= 1'b0;
      tcPulse <= 1'b0;
    end else begin
      tcPulse <= termEvent;
      if (reload) begin
        halted <= 1'b0;
      end else if (termEvent && !wrapMode) begin
        halted <= 1'b1;
      end
    end
  end

  // R5
  reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> !tcPulse)
    else $error("pulse right after reload");

  // R4
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !reload) |=> (halted && !tcPulse))
    else $error("halt released without reload");

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tcPulse && !TERM_IS_SEED) |=> !tcPulse)
    else $error("pulse wider than one cycle");

endmodule

// File: rtl/lfsr_tc_timer.sv
module lfsr_tc_timer
  import lfsr_tc_pkg::*;
#(
  parameter int unsigned WIDTH       = 7,
  parameter int unsigned TAP_HI      = 7,
  parameter int unsigned TAP_LO      = 6,
  parameter bit          FULL_PERIOD = 1'b0,
  parameter logic [WIDTH-1:0] SEED       = 7'h01,
  parameter logic [WIDTH-1:0] TERM_STATE = 7'h40
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic reload,
  input  logic wrapMode,
  output logic tcPulse
);

  localparam bit TERM_IS_SEED = (TERM_STATE == SEED);

  ctrlStrobes_t strb;
  logic         atTerm;

  lfsr_tc_datapath #(
    .WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
    .FULL_PERIOD(FULL_PERIOD), .SEED(SEED), .TERM_STATE(TERM_STATE)
  ) i_datapath (
    .clk(clk), .rst(rst), .strb(strb), .atTerm(atTerm)
  );

  lfsr_tc_ctrl #(
    .TERM_IS_SEED(TERM_IS_SEED)
  ) i_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .reload(reload),
    .wrapMode(wrapMode), .atTerm(atTerm), .strb(strb), .tcPulse(tcPulse)
  );

endmodule

// File: tb/test_lfsr_tc_timer.sv
module test_lfsr_tc_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SEED_V = 7'h5A;

  // Reference sequence: shift left, feedback from bits 6 and 5 (R9)
  function automatic logic [6:0] refNext(logic [6:0] s, bit full);
    logic fb;
    fb = s[6] ^ s[5];
    if (full && (s[5:0] == 6'd0)) fb = ~fb;
    return {s[5:0], fb};
  endfunction

  function automatic logic [6:0] refAdvance(logic [6:0] s, int n, bit full);
    logic [6:0] v;
    v = s;
    for (int i = 0; i < n; i++) v = refNext(v, full);
    return v;
  endfunction

  function automatic int refStepsTo(logic [6:0] s, logic [6:0] t, bit full);
    logic [6:0] v;
    v = s;
    for (int i = 0; i < 130; i++) begin
      if (v == t) return i;
      v = refNext(v, full);
    end
    return -1;
  endfunction

  localparam int         PLAIN_STEPS = 10;
  localparam logic [6:0] PLAIN_TERM  = refAdvance(SEED_V, PLAIN_STEPS, 1'b0);
  localparam int         FULL_STEPS  = refStepsTo(SEED_V, 7'h00, 1'b1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic reload = 1'b0;
  logic wrapMode = 1'b1;
  logic tcPlain, tcFull;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 1'b0;

  int qPlain[$];
  int qFull[$];

  // Reference counters
  int  cntP = 0, cntF = 0;
  bit  haltP = 0, haltF = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfsr_tc_timer #(
    .FULL_PERIOD(1'b0), .SEED(SEED_V), .TERM_STATE(PLAIN_TERM)
  ) i_lfsr_tc_timer (
    .clk(clk), .rst(rst), .enable(enable), .reload(reload),
    .wrapMode(wrapMode), .tcPulse(tcPlain)
  );

  lfsr_tc_timer #(
    .FULL_PERIOD(1'b1), .SEED(SEED_V), .TERM_STATE(7'h00)
  ) i_lfsr_tc_timer_full (
    .clk(clk), .rst(rst), .enable(enable), .reload(reload),
    .wrapMode(wrapMode), .tcPulse(tcFull)
  );

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
  endtask

  // Driver: one cycle of stimulus, expectations pushed for the next edge
  task automatic tick(bit en, bit rl, bit wm);
    @(negedge clk);
    enable = en; reload = rl; wrapMode = wm;
    if (rl) begin
      cntP = 0; haltP = 0; cntF = 0; haltF = 0;
    end else if (en) begin
      if (!haltP) begin
        if (cntP == PLAIN_STEPS) begin
          qPlain.push_back(cyc + 1);
          cntP = 0;
          if (!wm) haltP = 1;
        end else cntP++;
      end
      if (!haltF) begin
        if (cntF == FULL_STEPS) begin
          qFull.push_back(cyc + 1);
          cntF = 0;
          if (!wm) haltF = 1;
        end else cntF++;
      end
    end
  endtask

  task automatic scoreOne(string name, logic tc, ref int q[$]);
    while (q.size() > 0 && q[0] < cyc) begin
      checks++;
      fail(curReq, {name, " missing pulse"}, 0, q[0]);
      void'(q.pop_front());
    end
    if (tc === 1'b1) begin
      checks++;
      if (q.size() > 0 && q[0] == cyc) void'(q.pop_front());
      else fail(curReq, {name, " unexpected pulse at cycle"}, cyc, (q.size() > 0) ? q[0] : -1);
    end else if (tc !== 1'b0) begin
      checks++;
      fail(curReq, {name, " unknown pulse value"}, 0, 0);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      scoreOne("plain", tcPlain, qPlain);
      scoreOne("full", tcFull, qFull);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fail("watchdog", "run did not finish", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (tcPlain !== 1'b0 || tcFull !== 1'b0) fail("R1", "pulse during reset", tcPlain, 0);
    @(negedge clk);
    rst = 1'b0;
    tick(0, 0, 1);
    @(negedge clk);
    checks++;
    if (tcPlain !== 1'b0 || tcFull !== 1'b0) fail("R1", "pulse after reset", tcFull, 0);
    checks++;
    if (FULL_STEPS < 1) fail("R6", "zero state unreachable in reference", FULL_STEPS, 1);

    // R2 R7: continuous restart mode
    curReq = "R2";
    repeat (3 * (FULL_STEPS + 1) + 5) tick(1, 0, 1);

    // R3: enable gaps
    curReq = "R3";
    for (int i = 0; i < 200; i++) tick((i % 3) != 1, 0, 1);
    repeat (7) tick(0, 0, 1);

    // R5: reload mid count, and together with enable
    curReq = "R5";
    tick(0, 1, 1);
    repeat (6) tick(1, 0, 1);
    tick(1, 1, 1);
    repeat (5) tick(1, 0, 1);
    tick(1, 1, 1);
    repeat (PLAIN_STEPS * 3) tick(1, 0, 1);

    // R4: halt mode, one pulse each then silence
    curReq = "R4";
    tick(0, 1, 0);
    repeat (300) tick(1, 0, 0);
    for (int i = 0; i < 40; i++) tick(i[0], 0, 1);

    // R6: restart after halt, several full periods through zero
    curReq = "R6";
    tick(0, 1, 1);
    repeat (4 * (FULL_STEPS + 1)) tick(1, 0, 1);
    repeat (4) tick(0, 0, 1);

    @(negedge clk);
    done = 1'b1;
    while (qPlain.size() > 0) begin
      checks++; fail("R2", "plain missing pulse", 0, qPlain.pop_front());
    end
    while (qFull.size() > 0) begin
      checks++; fail("R6", "full missing pulse", 0, qFull.pop_front());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule